// File: doc/BRIEF.md
# Adaptive Model Counter Update with Fractional Rescale

This block keeps the occurrence counters of a small direct-mapped model cache for an adaptive arithmetic coder and updates them after every coded symbol. A hit adds one to the counter of the hit line. When the model is full, meaning the cached counters plus the constant escape mass already reach the fixed-point value of one, another line gives up one count in the same cycle so that the total does not change. A rotating pointer chooses that line. Lines whose counter is at the minimum are never chosen.

A miss empties the missed line. The replacement counter fetched from the backing RAM arrives on a separate load port one or more cycles later and overwrites a line directly. If a load leaves the total above one, the block scales every cached counter at the next clock edge. It uses the largest factor among 7/8, 6/8, 5/8 and 4/8 that brings the total back to one or below, so the scaling step stays off the path that handles the load. The escape mass is never scaled. The block drives the counters and the total from registers. The coding arithmetic is done elsewhere.

Top module: `model_adapt`

## Requirements
- R1: After synchronous reset every line counter equals INIT_CNT, the total equals N_LINES*INIT_CNT + ESC_VAL, and the decrement pointer is at line 0.
- R2: A hit (evt_valid=1, evt_hit=1) on line h while the total is below ONE_VAL raises counter h by one at the next edge and leaves the other lines unchanged.
- R3: A hit on line h while the total is at or above ONE_VAL raises counter h by one and lowers one other line by one at the same edge, so the total is unchanged.
- R4: The line that is lowered is the first line, in rising index order with wrap, starting at the decrement pointer, that is not h and whose counter exceeds MIN_CNT. After a decrement the pointer moves to that line plus one, modulo N_LINES. A pointer that equals h therefore moves past h.
- R5: Lines whose counter is at MIN_CNT or lower are skipped by the decrement search. If no line qualifies, the hit changes nothing.
- R6: A miss (evt_valid=1, evt_hit=0) on line m sets counter m to zero at the next edge.
- R7: A load (ram_valid=1) writes ram_count into line ram_line at the next edge. A load takes precedence over a miss on the same line in the same cycle.
- R8: When the registered total exceeds ONE_VAL, the next edge replaces every counter c by floor(c*k/8). Here k is the largest of 7, 6, 5, 4 for which the sum of the scaled counters plus ESC_VAL is at most ONE_VAL. Loads, misses and hits in that cycle act on the scaled values.
- R9: If even k=4 leaves the total above ONE_VAL, k=4 is still applied, and the scaling is repeated at the following edge.
- R10: A hit on the line that is being loaded in the same cycle is ignored. The line takes the loaded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | A coded-symbol event is present |
| evt_hit | input | 1 | 1 = hit, 0 = miss |
| evt_line | input | LW | Cache line of the event |
| ram_valid | input | 1 | Replacement counter from RAM is present |
| ram_line | input | LW | Line receiving the replacement counter |
| ram_count | input | CNT_W | Replacement counter value |
| cnt_flat | output | N_LINES*CNT_W | Registered counters, line i at bits [i*CNT_W +: CNT_W] |
| total | output | TW | Registered sum of all counters plus ESC_VAL |

## Verification
A cycle can combine the deferred rescale with a hit. The rescale is triggered by the previous cycle's load, and the hit arrives in the cycle where that scaling is pending. The bench provokes this by loading a large counter and hitting another line on the very next cycle. It expects the hit line to hold its scaled value plus one, with the saturation decision based on the scaled total rather than the stale one. The same overlap with loads is provoked over a chain of back-to-back loads that needs a fallback halving followed by a 7/8 step, and each resulting counter is compared with values worked out from the rules above.

// File: rtl/madapt_pkg.sv
package madapt_pkg;
  // Rescale factor code: value + 4 gives the numerator over 8
  typedef enum logic [1:0] {
    FR_4_8 = 2'd0,
    FR_5_8 = 2'd1,
    FR_6_8 = 2'd2,
    FR_7_8 = 2'd3
  } frac_e;
endpackage

// File: rtl/madapt_sum.sv
module madapt_sum #(
  parameter int N   = 8,
  parameter int CW  = 12,
  parameter int TW  = 16,
  parameter int ESC = 64
) (
  input  logic [N*CW-1:0] cnt_i,
  output logic [TW-1:0]   sum_o
);
  always_comb begin
    sum_o = TW'(ESC);
    for (int i = 0; i < N; i++) begin
      sum_o = sum_o + TW'(cnt_i[i*CW +: CW]);
    end
  end
endmodule

// File: rtl/madapt_scaler.sv
module madapt_scaler #(
  parameter int N   = 8,
  parameter int CW  = 12,
  parameter int TW  = 16,
  parameter int ONE = 1024,
  parameter int ESC = 64
) (
  input  logic [N*CW-1:0]      cnt_i,
  output logic [N*CW-1:0]      scaled_o,
  output madapt_pkg::frac_e    frac_o
);
  localparam int XW = CW + 3;

  logic [CW-1:0] prod [4][N];
  logic [TW-1:0] psum [4];
  logic [3:0]    fits;

  // Shift-and-add product c*k/8 for each candidate k, truncated toward zero
  for (genvar kk = 0; kk < 4; kk++) begin : g_fac
    localparam logic [2:0] MUL = 3'(4 + kk);
    for (genvar i = 0; i < N; i++) begin : g_line
      logic [XW-1:0] wide;
      logic [XW-1:0] c_ext;
      assign c_ext = XW'(cnt_i[i*CW +: CW]);
      assign wide  = (c_ext << 2)
                   + (MUL[1] ? (c_ext << 1) : '0)
                   + (MUL[0] ? c_ext : '0);
      assign prod[kk][i] = CW'(wide >> 3);
    end
    always_comb begin
      psum[kk] = TW'(ESC);
      for (int i = 0; i < N; i++) begin
        psum[kk] = psum[kk] + TW'(prod[kk][i]);
      end
    end
    assign fits[kk] = (psum[kk] <= TW'(ONE));
  end

  // Largest fitting factor wins; fall back to one half
  always_comb begin
    frac_o = madapt_pkg::FR_4_8;
    if (fits[3])      frac_o = madapt_pkg::FR_7_8;
    else if (fits[2]) frac_o = madapt_pkg::FR_6_8;
    else if (fits[1]) frac_o = madapt_pkg::FR_5_8;
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      scaled_o[i*CW +: CW] = prod[frac_o][i];
    end
  end
endmodule

// File: rtl/madapt_victim.sv
module madapt_victim #(
  parameter int N    = 8,
  parameter int CW   = 12,
  parameter int LW   = 3,
  parameter int MINC = 1
) (
  input  logic [N*CW-1:0] cnt_i,
  input  logic [LW-1:0]   ptr_i,
  input  logic [LW-1:0]   excl_i,
  output logic            found_o,
  output logic [LW-1:0]   idx_o
);
  // Rotating priority search starting at the pointer
  always_comb begin
    logic [LW-1:0] cand;
    found_o = 1'b0;
    idx_o   = ptr_i;
    for (int j = 0; j < N; j++) begin
      cand = ptr_i + LW'(j);
      if (!found_o && cand != excl_i &&
          cnt_i[cand*CW +: CW] > CW'(MINC)) begin
        found_o = 1'b1;
        idx_o   = cand;
      end
    end
  end
endmodule

// File: rtl/model_adapt.sv
module model_adapt #(
  parameter int N_LINES  = 8,
  parameter int CNT_W    = 12,
  parameter int ONE_VAL  = 1024,
  parameter int ESC_VAL  = 64,
  parameter int INIT_CNT = 100,
  parameter int MIN_CNT  = 1,
  localparam int LW      = $clog2(N_LINES),
  localparam int TW      = CNT_W + LW + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     evt_valid,
  input  logic                     evt_hit,
  input  logic [LW-1:0]            evt_line,
  input  logic                     ram_valid,
  input  logic [LW-1:0]            ram_line,
  input  logic [CNT_W-1:0]         ram_count,
  output logic [N_LINES*CNT_W-1:0] cnt_flat,
  output logic [TW-1:0]            total
);
  localparam int FW = N_LINES * CNT_W;

  logic [CNT_W-1:0] cnt_q [N_LINES];
  logic [TW-1:0]    total_q;
  logic [LW-1:0]    ptr_q;

  logic [CNT_W-1:0] y_c [N_LINES];
  logic [CNT_W-1:0] z_c [N_LINES];
  logic [LW-1:0]    ptr_n;

  logic [FW-1:0]    cur_flat, scl_flat, y_flat, z_flat;
  logic [TW-1:0]    sum_y, total_n;
  logic             pend, sat, hit_ok, v_found;
  logic [LW-1:0]    v_idx;
  madapt_pkg::frac_e frac;

  for (genvar i = 0; i < N_LINES; i++) begin : g_flat
    assign cur_flat[i*CNT_W +: CNT_W] = cnt_q[i];
    assign y_flat[i*CNT_W +: CNT_W]   = y_c[i];
    assign z_flat[i*CNT_W +: CNT_W]   = z_c[i];
  end

  // Deferred rescale: decided from the registered total
  assign pend = (total_q > TW'(ONE_VAL));

  madapt_scaler #(.N(N_LINES), .CW(CNT_W), .TW(TW), .ONE(ONE_VAL), .ESC(ESC_VAL))
    u_scaler (.cnt_i(cur_flat), .scaled_o(scl_flat), .frac_o(frac));

  // Stage: scale, then miss clear, then RAM load
  always_comb begin
    for (int i = 0; i < N_LINES; i++) begin
      y_c[i] = pend ? scl_flat[i*CNT_W +: CNT_W] : cnt_q[i];
    end
    if (evt_valid && !evt_hit) y_c[evt_line] = '0;
    if (ram_valid)             y_c[ram_line] = ram_count;
  end

  madapt_sum #(.N(N_LINES), .CW(CNT_W), .TW(TW), .ESC(ESC_VAL))
    u_sum_pre (.cnt_i(y_flat), .sum_o(sum_y));

  assign sat    = (sum_y >= TW'(ONE_VAL));
  assign hit_ok = evt_valid && evt_hit && !(ram_valid && ram_line == evt_line);

  madapt_victim #(.N(N_LINES), .CW(CNT_W), .LW(LW), .MINC(MIN_CNT))
    u_victim (.cnt_i(y_flat), .ptr_i(ptr_q), .excl_i(evt_line),
              .found_o(v_found), .idx_o(v_idx));

  // Stage: increment, with compensation when saturated
  always_comb begin
    for (int i = 0; i < N_LINES; i++) z_c[i] = y_c[i];
    ptr_n = ptr_q;
    if (hit_ok) begin
      if (!sat) begin
        z_c[evt_line] = y_c[evt_line] + CNT_W'(1);
      end else if (v_found) begin
        z_c[evt_line] = y_c[evt_line] + CNT_W'(1);
        z_c[v_idx]    = y_c[v_idx] - CNT_W'(1);
        ptr_n         = v_idx + LW'(1);
      end
    end
  end

  madapt_sum #(.N(N_LINES), .CW(CNT_W), .TW(TW), .ESC(ESC_VAL))
    u_sum_post (.cnt_i(z_flat), .sum_o(total_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_LINES; i++) cnt_q[i] <= CNT_W'(INIT_CNT);
      total_q <= TW'(N_LINES * INIT_CNT + ESC_VAL);
      ptr_q   <= '0;
    end else begin
      for (int i = 0; i < N_LINES; i++) cnt_q[i] <= z_c[i];
      total_q <= total_n;
      ptr_q   <= ptr_n;
    end
  end

  assign cnt_flat = cur_flat;
  assign total    = total_q;

  // Requirement checks
  assert_hit_grow_R2: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_hit && !ram_valid && !pend && total_q < TW'(ONE_VAL))
    |=> (total_q == $past(total_q) + TW'(1)));

  assert_sat_keep_R3: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_hit && !ram_valid && !pend && total_q == TW'(ONE_VAL))
    |=> (total_q == $past(total_q)));

  assert_victim_legal_R5: assert property (@(posedge clk) disable iff (rst)
    (hit_ok && sat && v_found)
    |-> (v_idx != evt_line && y_c[v_idx] > CNT_W'(MIN_CNT)));

  assert_miss_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !evt_hit && !(ram_valid && ram_line == evt_line))
    |=> (cnt_q[$past(evt_line)] == '0));

  assert_ram_load_R7: assert property (@(posedge clk) disable iff (rst)
    ram_valid |=> (cnt_q[$past(ram_line)] == $past(ram_count)));

  assert_rescale_shrinks_R8: assert property (@(posedge clk) disable iff (rst)
    (pend && !evt_valid && !ram_valid) |=> (total_q < $past(total_q)));
endmodule

// File: tb/model_adapt_tb_top.sv
module model_adapt_tb_top;
  localparam int N = 8, CW = 12, LW = 3, TW = 16;
  localparam int ONE = 1024, ESC = 64, INIT = 100, MINC = 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          evt_valid = 0, evt_hit = 0, ram_valid = 0;
  logic [LW-1:0] evt_line = '0, ram_line = '0;
  logic [CW-1:0] ram_count = '0;
  logic [N*CW-1:0] cnt_flat;
  logic [TW-1:0]   total;

  model_adapt dut_i (
    .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_hit(evt_hit),
    .evt_line(evt_line), .ram_valid(ram_valid), .ram_line(ram_line),
    .ram_count(ram_count), .cnt_flat(cnt_flat), .total(total));

  int n_chk = 0, n_bad = 0;
  int m_cnt [N];
  int m_ptr, m_total;

  // Stimulus table: {ev, hit, line[2:0], rv, rline[2:0], rcount[11:0]}
  localparam int NV = 16;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1,1'b1,3'd2,1'b0,3'd0,12'd0},
    {1'b1,1'b1,3'd5,1'b0,3'd0,12'd0},
    {1'b1,1'b0,3'd6,1'b0,3'd0,12'd0},
    {1'b0,1'b0,3'd0,1'b1,3'd6,12'd300},
    {1'b1,1'b1,3'd6,1'b0,3'd0,12'd0},
    {1'b0,1'b0,3'd0,1'b1,3'd1,12'd157},
    {1'b1,1'b1,3'd0,1'b0,3'd0,12'd0},
    {1'b1,1'b1,3'd1,1'b0,3'd0,12'd0},
    {1'b0,1'b0,3'd0,1'b1,3'd3,12'd500},
    {1'b1,1'b1,3'd4,1'b0,3'd0,12'd0},
    {1'b0,1'b0,3'd0,1'b0,3'd0,12'd0},
    {1'b1,1'b0,3'd2,1'b1,3'd2,12'd80},
    {1'b1,1'b1,3'd7,1'b0,3'd0,12'd0},
    {1'b1,1'b1,3'd0,1'b1,3'd0,12'd900},
    {1'b0,1'b0,3'd0,1'b0,3'd0,12'd0},
    {1'b1,1'b1,3'd3,1'b0,3'd0,12'd0}
  };

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int dut_cnt(int i);
    return int'(cnt_flat[i*CW +: CW]);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_cnt[i] = INIT;
    m_ptr = 0;
    m_total = N * INIT + ESC;
  endtask

  // Reference behaviour written from the requirements
  task automatic model_step(bit ev, bit hit, int line, bit rv, int rl, int rc);
    int y [N];
    int s, k;
    bit done;
    for (int i = 0; i < N; i++) y[i] = m_cnt[i];
    if (m_total > ONE) begin                       // R8 / R9
      k = 4;
      done = 0;
      for (int kk = 7; kk >= 4; kk--) begin
        s = ESC;
        for (int i = 0; i < N; i++) s += (m_cnt[i] * kk) / 8;
        if (!done && s <= ONE) begin k = kk; done = 1; end
      end
      for (int i = 0; i < N; i++) y[i] = (m_cnt[i] * k) / 8;
    end
    if (ev && !hit) y[line] = 0;                   // R6
    if (rv) y[rl] = rc;                            // R7
    s = ESC;
    for (int i = 0; i < N; i++) s += y[i];
    if (ev && hit && !(rv && rl == line)) begin    // R10
      if (s < ONE) y[line]++;                      // R2
      else begin                                   // R3 R4 R5
        done = 0;
        for (int j = 0; j < N; j++) begin
          int c = (m_ptr + j) % N;
          if (!done && c != line && y[c] > MINC) begin
            y[line]++;
            y[c]--;
            m_ptr = (c + 1) % N;
            done = 1;
          end
        end
      end
    end
    for (int i = 0; i < N; i++) m_cnt[i] = y[i];
    m_total = ESC;
    for (int i = 0; i < N; i++) m_total += y[i];
  endtask

  task automatic idle_inputs();
    evt_valid = 0; evt_hit = 0; evt_line = '0;
    ram_valid = 0; ram_line = '0; ram_count = '0;
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic apply(bit ev, bit hit, int line, bit rv, int rl, int rc);
    evt_valid = ev; evt_hit = hit; evt_line = LW'(line);
    ram_valid = rv; ram_line = LW'(rl); ram_count = CW'(rc);
    model_step(ev, hit, line, rv, rl, rc);
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_reset();
    rst = 1;
    idle_inputs();
    repeat (2) @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  task automatic compare_model(string tag);
    for (int i = 0; i < N; i++)
      check($sformatf("%s line%0d", tag, i), dut_cnt(i), m_cnt[i]);
    check($sformatf("%s total", tag), int'(total), m_total);
  endtask

  task automatic expect_all(string tag, int e [N], int et);
    for (int i = 0; i < N; i++)
      check($sformatf("%s line%0d", tag, i), dut_cnt(i), e[i]);
    check($sformatf("%s total", tag), int'(total), et);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    do_reset();

    // R1 reset state
    expect_all("R1 reset", '{100,100,100,100,100,100,100,100}, 864);

    // Table walk against the reference behaviour
    for (int v = 0; v < NV; v++) begin
      logic [20:0] e;
      e = VEC[v];
      apply(e[20], e[19], int'(e[18:16]), e[15], int'(e[14:12]), int'(e[11:0]));
      compare_model($sformatf("table%0d R2-path", v));
    end

    // R2 unsaturated hit
    do_reset();
    apply(1, 1, 3, 0, 0, 0);
    expect_all("R2 hit", '{100,100,100,101,100,100,100,100}, 865);

    // R6 miss clears, R10 hit on loading line ignored
    do_reset();
    apply(1, 0, 4, 0, 0, 0);
    expect_all("R6 miss", '{100,100,100,100,0,100,100,100}, 764);
    do_reset();
    apply(1, 1, 1, 1, 1, 200);
    expect_all("R10 hit_on_load R7", '{100,200,100,100,100,100,100,100}, 964);

    // R8 7/8 rescale then R2, R3, R4 on saturated model
    do_reset();
    apply(0, 0, 0, 1, 2, 400);
    expect_all("R7 load", '{100,100,400,100,100,100,100,100}, 1164);
    apply(0, 0, 0, 0, 0, 0);
    expect_all("R8 seven_eighths", '{87,87,350,87,87,87,87,87}, 1023);
    apply(1, 1, 0, 0, 0, 0);
    expect_all("R2 to_full", '{88,87,350,87,87,87,87,87}, 1024);
    apply(1, 1, 0, 0, 0, 0);
    expect_all("R3 compensate", '{89,86,350,87,87,87,87,87}, 1024);
    apply(1, 1, 2, 0, 0, 0);
    expect_all("R4 pointer_skips_hit", '{89,86,351,86,87,87,87,87}, 1024);

    // R5 lines at minimum are skipped
    do_reset();
    apply(0, 0, 0, 1, 1, 1);
    apply(0, 0, 0, 1, 2, 1);
    apply(0, 0, 0, 1, 0, 458);
    expect_all("R5 setup", '{458,1,1,100,100,100,100,100}, 1024);
    apply(1, 1, 0, 0, 0, 0);
    expect_all("R5 skip_min", '{459,1,1,99,100,100,100,100}, 1024);

    // Rescale pending in the same cycle as a hit (R8 with R2)
    do_reset();
    apply(0, 0, 0, 1, 0, 1023);
    apply(1, 1, 3, 0, 0, 0);
    expect_all("R8 hit_during_rescale", '{511,50,50,51,50,50,50,50}, 926);

    // R9 fallback halving, then R8 7/8
    do_reset();
    apply(0, 0, 0, 1, 0, 1023);
    apply(0, 0, 0, 1, 1, 1023);
    apply(0, 0, 0, 1, 2, 1023);
    apply(0, 0, 0, 1, 3, 1023);
    expect_all("R8 chain", '{127,255,511,1023,12,12,12,12}, 2028);
    apply(0, 0, 0, 0, 0, 0);
    expect_all("R9 half_not_enough", '{63,127,255,511,6,6,6,6}, 1044);
    apply(0, 0, 0, 0, 0, 0);
    expect_all("R8 after_fallback", '{55,111,223,447,5,5,5,5}, 920);
    apply(0, 0, 0, 0, 0, 0);
    expect_all("R8 settled", '{55,111,223,447,5,5,5,5}, 920);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule